// File: doc/BRIEF.md
# Synchronizer Late-Resolution Event Counter

This block is an on-chip test structure for measuring how often a single-stage synchronizer is slow to settle. Each copy has a launch flop in a first clock domain that inverts on every cycle of that clock, so the data into the synchronizer toggles as fast as it can. One flop clocked by a second, unrelated clock samples that data. Two capture flops then read the synchronizer output: one on the falling edge of the second clock and one on the following rising edge. If the two captures of the same synchronizer cycle disagree, the output had not settled by the half-period point, and one event is counted.

The block holds a parameterised number of these copies and runs them one at a time. A start pulse clears every counter and then enables copy 0, copy 1, and so on up to the last copy. Each copy gets a window of a fixed number of second-clock cycles. Copies that are not selected keep their launch flop frozen. After the last window the block raises a done flag and keeps it high, and each copy's count can then be read by selecting the copy's index.

Top module: `meta_event_monitor`

## Requirements
- R1: After reset, busy and done are 0 and rd_count reads 0 for every index.
- R2: A start pulse taken while idle or done sets busy to 1 and done to 0 from the next rising clk_b edge.
- R3: If start is sampled at clk_b edge s, busy falls and done rises at edge s + NUM_INST*WINDOW_CYCLES and not earlier. During a run busy and done are never both 1.
- R4: Once set, done stays 1 until the next accepted start.
- R5: Each clk_b cycle in which the falling-edge capture and the following rising-edge capture of the synchronizer output disagree adds exactly one to the count of the instance that is active at that time.
- R6: Instances are enabled one at a time in index order. Instance i is active for the window covering edges s + i*WINDOW_CYCLES through s + (i+1)*WINDOW_CYCLES - 1.
- R7: A mismatch in an instance that is not active does not change any count.
- R8: Each count saturates at 2^CNT_W - 1 and does not wrap.
- R9: An accepted start clears every count to 0 at the edge where it is sampled.
- R10: A start pulse that arrives while busy is 1 is ignored and does not change when done rises.
- R11: rd_count shows the count of the instance whose binary index is on rd_idx, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Launch clock, unrelated to clk_b |
| clk_b | input | 1 | Sampling and control clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| start | input | 1 | One-cycle pulse in the clk_b domain that begins a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | All windows finished; stays high until the next start |
| rd_idx | input | IDX_W | Index of the instance to read |
| rd_count | output | CNT_W | Event count of the selected instance |

## Verification
In simulation the synchronizer always settles, so the bench creates late resolution on purpose. It overrides one instance's synchronizer output so that it holds one value across a falling edge and the opposite value across the next rising edge. Injections into the active instance test single counting and the window boundaries. Injections into an idle instance test that gating works. A burst of nine injections against a 3-bit count tests saturation and tells it apart from wrap-around. A second run tests clearing and the order of windows, and a start pulse in the middle of a run tests that the window length stays fixed.

// File: rtl/meta_mon_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the late-resolution event counter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package meta_mon_pkg;

    // Run sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_t;

endpackage

// File: rtl/mm_cell.sv
`timescale 1ns/1ps
// Module: mm_cell
// One measurement structure. A launch flop in the clk_a domain inverts every
// cycle while enabled. A single clk_b flop samples it. A falling-edge capture
// and a rising-edge capture of that flop are compared after alignment, and
// a mismatch gives a one-cycle err_b pulse.
// Assumes: enable_b comes from a clk_b register and is brought into clk_a
// through two flops here. rst_n is held for several cycles of both clocks.
module mm_cell (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic enable_b,
    output logic err_b
);

    logic en_s1, en_s2;
    logic launch_q;
    logic sync_q;
    logic half_q;
    logic half_al_q;
    logic full_q;

    // Bring the enable into the launch domain
    always_ff @(posedge clk_a) begin
        if (!rst_n) begin
            en_s1 <= 1'b0;
            en_s2 <= 1'b0;
        end else begin
            en_s1 <= enable_b;
            en_s2 <= en_s1;
        end
    end

    // Launch flop: toggles every clk_a cycle while enabled, else frozen
    always_ff @(posedge clk_a) begin
        if (!rst_n)
            launch_q <= 1'b0;
        else if (en_s2)
            launch_q <= ~launch_q;
    end

    // Single synchronizing flop in the clk_b domain
    always_ff @(posedge clk_b) begin
        if (!rst_n)
            sync_q <= 1'b0;
        else
            sync_q <= launch_q;
    end

    // Half-period capture on the falling edge of clk_b
    always_ff @(negedge clk_b) begin
        if (!rst_n)
            half_q <= 1'b0;
        else
            half_q <= sync_q;
    end

    // Full-period capture, plus the half capture realigned to the same cycle
    always_ff @(posedge clk_b) begin
        if (!rst_n) begin
            full_q    <= 1'b0;
            half_al_q <= 1'b0;
        end else begin
            full_q    <= sync_q;
            half_al_q <= half_q;
        end
    end

    // Registered mismatch flag
    always_ff @(posedge clk_b) begin
        if (!rst_n)
            err_b <= 1'b0;
        else
            err_b <= half_al_q ^ full_q;
    end

endmodule

// File: rtl/mm_err_counter.sv
`timescale 1ns/1ps
// Module: mm_err_counter
// Saturating event counter for one instance. clr wins over inc.
// Assumes: inc is already gated by the instance's active window.
module mm_err_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear, count up, or hold at the maximum
    always_ff @(posedge clk_b) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc && (count != CNT_MAX))
            count <= count + 1'b1;
    end

    // R9: a clear empties the counter
    p_clear_r9: assert property (@(posedge clk_b) disable iff (!rst_n)
        clr |=> (count == '0));
    // R8: the maximum is held and never wraps
    p_no_overflow_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!clr && count == CNT_MAX) |=> (count == CNT_MAX));
    // R5: one event adds exactly one
    p_step_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
        (inc && !clr && count != CNT_MAX) |=> (count == $past(count) + 1'b1));
    // R7: no event, no change
    p_hold_r7: assert property (@(posedge clk_b) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));

endmodule

// File: rtl/mm_sequencer.sv
`timescale 1ns/1ps
// Module: mm_sequencer
// Runs the instances one after another, each for WINDOW_CYCLES clk_b
// cycles, in index order. An accepted start clears the counters. done
// stays high after the last window until the next accepted start.
// Assumes: start is a clk_b-synchronous pulse.
module mm_sequencer
    import meta_mon_pkg::*;
#(
    parameter int          NUM_INST      = 8,
    parameter int unsigned WINDOW_CYCLES = 32'd3_000_000_000
) (
    input  logic                clk_b,
    input  logic                rst_n,
    input  logic                start,
    output logic [NUM_INST-1:0] sel,
    output logic                clr,
    output logic                busy,
    output logic                done
);

    localparam int IDX_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
    localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYCLES - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_INST - 1);

    seq_state_t       state;
    logic [IDX_W-1:0] idx;
    logic [WIN_W-1:0] win_cnt;

    // Accept start only when no run is in progress
    assign clr  = start && (state != SQ_RUN);
    assign busy = (state == SQ_RUN);
    assign done = (state == SQ_DONE);

    // State, window position and active index
    always_ff @(posedge clk_b) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            idx     <= '0;
            win_cnt <= '0;
        end else if (clr) begin
            state   <= SQ_RUN;
            idx     <= '0;
            win_cnt <= '0;
        end else if (state == SQ_RUN) begin
            if (win_cnt == WIN_LAST) begin
                win_cnt <= '0;
                if (idx == IDX_LAST)
                    state <= SQ_DONE;
                else
                    idx <= idx + 1'b1;
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

    // One select line per instance, decoded from the active index
    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_sel
        assign sel[gi] = (state == SQ_RUN) && (idx == IDX_W'(gi));
    end

    // R6: at most one instance enabled
    p_one_active_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
        $onehot0(sel));
    // R4: done is held until a start
    p_done_sticky_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        (done && !start) |=> done);
    // R3: never busy and done together
    p_excl_r3: assert property (@(posedge clk_b) disable iff (!rst_n)
        !(busy && done));
    // R10: a start during a run does not restart it
    p_no_restart_r10: assert property (@(posedge clk_b) disable iff (!rst_n)
        (busy && start && !$past(clr)) |=> (busy || done));
    // R2: an accepted start enters the run
    p_start_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        clr |=> (busy && !done));

endmodule

// File: rtl/meta_event_monitor.sv
`timescale 1ns/1ps
// Module: meta_event_monitor (top)
// NUM_INST measurement cells, one saturating counter per cell, a sequencer
// that enables the cells one at a time, and a readout multiplexer.
// Assumes: clk_a and clk_b are unrelated. start and rd_idx belong to clk_b.
module meta_event_monitor #(
    parameter int          NUM_INST      = 8,
    parameter int unsigned WINDOW_CYCLES = 32'd3_000_000_000,
    parameter int          CNT_W         = 32,
    localparam int         IDX_W         = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_count
);

    logic [NUM_INST-1:0] sel;
    logic [NUM_INST-1:0] err;
    logic                clr;
    logic [CNT_W-1:0]    cnt_arr [NUM_INST];

    mm_sequencer #(
        .NUM_INST      (NUM_INST),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) u_seq (
        .clk_b (clk_b),
        .rst_n (rst_n),
        .start (start),
        .sel   (sel),
        .clr   (clr),
        .busy  (busy),
        .done  (done)
    );

    for (genvar gi = 0; gi < NUM_INST; gi++) begin : g_inst
        mm_cell u_cell (
            .clk_a    (clk_a),
            .clk_b    (clk_b),
            .rst_n    (rst_n),
            .enable_b (sel[gi]),
            .err_b    (err[gi])
        );
        mm_err_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk_b (clk_b),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (err[gi] && sel[gi]),
            .count (cnt_arr[gi])
        );
    end

    // Readout: pick the selected instance's count
    always_comb begin
        rd_count = '0;
        for (int i = 0; i < NUM_INST; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_count = cnt_arr[i];
        end
    end

endmodule

// File: tb/meta_event_monitor_test.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected counts. The driver queues expected reads and
// a monitor drives rd_idx and compares. Late resolution is injected by
// overriding one cell's synchronizer flop across a falling/rising edge pair.
module meta_event_monitor_test;

    localparam int N   = 4;
    localparam int W   = 60;
    localparam int CW  = 3;
    localparam int IW  = 2;

    logic          clk_a = 1'b0;
    logic          clk_b = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [IW-1:0] rd_idx = '0;
    logic [CW-1:0] rd_count;

    int n_checks = 0;
    int n_fail   = 0;
    int rel      = 0;
    bit finished = 1'b0;

    typedef struct {
        int    idx;
        int    val;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    meta_event_monitor #(
        .NUM_INST(N), .WINDOW_CYCLES(W), .CNT_W(CW)
    ) uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_count(rd_count)
    );

    always #10 clk_b = ~clk_b;
    always #7  clk_a = ~clk_a;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: applies each queued index and compares the count
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            rd_idx = IW'(sb_q[0].idx);
            #2;
            check(int'(rd_count) == sb_q[0].val, sb_q[0].tag, int'(rd_count), sb_q[0].val);
            void'(sb_q.pop_front());
        end
    end

    // Driver: queue an expected read and wait for the monitor to take it
    task automatic expect_read(input int idx, input int val, input string tag);
        exp_t e;
        e.idx = idx; e.val = val; e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    // Advance n rising edges, ending 1 ns after the last
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk_b);
            rel++;
        end
        #1;
    endtask

    task automatic step_to(input int target);
        if (target > rel) step(target - rel);
    endtask

    task automatic pulse_start();
        @(negedge clk_b);
        start = 1'b1;
        @(posedge clk_b);
        rel++;
        #1 start = 1'b0;
    endtask

    // One late-resolution event: sync flop reads 1 at the fall, 0 at the rise
    task automatic inject(input int k);
        #7;
        case (k)
            0: force uut.g_inst[0].u_cell.sync_q = 1'b1;
            1: force uut.g_inst[1].u_cell.sync_q = 1'b1;
            2: force uut.g_inst[2].u_cell.sync_q = 1'b1;
            default: force uut.g_inst[3].u_cell.sync_q = 1'b1;
        endcase
        #4;
        case (k)
            0: force uut.g_inst[0].u_cell.sync_q = 1'b0;
            1: force uut.g_inst[1].u_cell.sync_q = 1'b0;
            2: force uut.g_inst[2].u_cell.sync_q = 1'b0;
            default: force uut.g_inst[3].u_cell.sync_q = 1'b0;
        endcase
        @(posedge clk_b);
        rel++;
        #1;
        case (k)
            0: release uut.g_inst[0].u_cell.sync_q;
            1: release uut.g_inst[1].u_cell.sync_q;
            2: release uut.g_inst[2].u_cell.sync_q;
            default: release uut.g_inst[3].u_cell.sync_q;
        endcase
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (6) @(posedge clk_b);
        #1 rst_n = 1'b1;
        step(2);
        // R1: reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        for (int i = 0; i < N; i++) expect_read(i, 0, "R1 count");

        // Run 1
        pulse_start();
        rel = 0;
        step(4);
        check(busy == 1'b1, "R2 busy", int'(busy), 1);
        check(done == 1'b0, "R2 done", int'(done), 0);
        inject(0);
        step(3);
        inject(0);
        step(3);
        inject(2);                       // R7: cell 2 idle during window 0
        step_to(29);
        pulse_start();                   // R10: ignored during run
        step_to(64);
        for (int j = 0; j < 9; j++) begin  // R8: nine events into a 3-bit count
            inject(1);
            step(3);
        end
        step_to(130);
        inject(2);
        step_to(N*W - 1);
        check(done == 1'b0, "R3 done early", int'(done), 0);
        check(busy == 1'b1, "R3 busy early", int'(busy), 1);
        step(1);
        check(done == 1'b1, "R3 done", int'(done), 1);
        check(busy == 1'b0, "R3 busy", int'(busy), 0);
        expect_read(0, 2, "R5 count0");
        expect_read(1, 7, "R8 saturation");
        expect_read(2, 1, "R7 idle ignored");
        expect_read(3, 0, "R11 count3");
        step(20);
        check(done == 1'b1, "R4 done held", int'(done), 1);

        // Run 2
        pulse_start();
        rel = 0;
        check(done == 1'b0, "R2 done cleared", int'(done), 0);
        check(busy == 1'b1, "R2 busy run2", int'(busy), 1);
        for (int i = 0; i < N; i++) expect_read(i, 0, "R9 cleared");
        step(1);
        step_to(3*W + 5);
        for (int j = 0; j < 3; j++) begin
            inject(3);
            step(3);
        end
        step_to(N*W);
        check(done == 1'b1, "R3 done run2", int'(done), 1);
        expect_read(0, 0, "R6 count0");
        expect_read(1, 0, "R6 count1");
        expect_read(2, 0, "R6 count2");
        expect_read(3, 3, "R6 window3");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule